// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two phase signals of an incremental encoder, together with an index pulse and a home switch, into a 32-bit signed position. Alongside the position it keeps a 16-bit difference count, the net steps taken since the last snapshot, and a 16-bit revolution count. Software reaches everything through a 16-bit register port. Each 32-bit quantity is split into an upper and a lower half. Reading the upper position half freezes a coherent copy of the position, the difference and the revolution count into hold registers.

The phase inputs are synchronised and then debounced by a programmable filter. They are decoded either as quadrature or as pulse-plus-direction, and the counting sense can be inverted. Index and home edges of a selectable polarity can reload the position. A modulo mode makes the position wrap between the initial value and a modulus. A compare register detects when a chosen position is reached. Five sticky flags are cleared by writing one to them, and each one can drive the interrupt output through its own enable.

Top module: `quad_pos_counter`

Register map (16-bit words, 4-bit address): 0 CTL, 1 CTL2, 2 FILT, 3/4 initial value hi/lo, 5/6 modulus hi/lo, 7/8 compare hi/lo, 9 position hi (snapshot read), 10/11 held position hi/lo, 12 difference, 13 held difference, 14 revolution, 15 held revolution.
CTL bits: 0 software load (write-only), 1 reverse, 2 pulse-direction mode, 3 index reload enable, 4 index falling edge, 5 home reload enable, 6 home falling edge, 7 index irq enable, 8 index flag, 9 home irq enable, 10 home flag, 11 compare irq enable, 12 compare flag.
CTL2 bits: 0 modulo enable, 1 revolution counts wrap events, 2 trigger loads zero, 3 trigger updates hold, 4 roll-over irq enable, 5 roll-over flag, 6 roll-under irq enable, 7 roll-under flag.
FILT: bits 2:0 sample count, bits 10:3 sample period.

## Requirements
- R1: After reset the position is 0, the compare register reads 0xFFFF in both halves, CTL reads 0 and irq is low.
- R2: In quadrature mode the phase sequence {A,B} = 00,10,11,01,00 counts up by one per step and the reverse sequence counts down; CTL bit 1 inverts the direction.
- R3: A filtered phase change in which A and B both toggle in the same sample is ignored and leaves the position unchanged.
- R4: With CTL bit 2 set, each rising edge of A counts one step, up when B is 0 and down when B is 1; B changes alone do not count.
- R5: Writing CTL with bit 0 set loads the 32-bit initial value into the position.
- R6: An index or home edge sets its flag (CTL bit 8 or 10); when its reload bit is set it also loads the initial value into the position; its polarity bit selects the falling edge instead of the rising edge.
- R7: With CTL2 bit 0 set, counting up from the modulus gives the initial value and sets CTL2 bit 5; counting down from the initial value gives the modulus and sets CTL2 bit 7.
- R8: With CTL2 bit 1 clear the revolution count moves by one on each index edge, in the direction of the last step; with it set it moves up on roll-over and down on roll-under.
- R9: The compare flag (CTL bit 12) is set when the position changes to a value equal to the compare register.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R11: A read of the position upper half copies position, difference and revolution into the hold registers and clears the difference count; the held lower half then matches the upper half that was read.
- R12: A phase change is accepted only after count+1 consecutive differing samples taken every period+1 cycles; shorter glitches do not count.
- R13: irq is high exactly when some flag and its enable bit are both set.
- R14: With CTL2 bit 2 a reload trigger loads zero instead of the initial value; with CTL2 bit 3 the trigger also copies the position into the hold registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Encoder phase A (count pulse in pulse-direction mode) |
| phase_b | input | 1 | Encoder phase B (direction in pulse-direction mode) |
| index_in | input | 1 | Index pulse |
| home_in | input | 1 | Home switch |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers snapshot at address 9) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit bus words, so a 32-bit position, two synchroniser stages, a 3-bit sample count and an 8-bit sample period. With these values the test can start the position just below a 16-bit boundary and carry it across, so the snapshot has to join two halves that differ. A short filter setting (count 3, period 1) lets a glitch rejection and an accepted change both finish within a few tens of cycles. The modulo and compare cases use small limits, so that wrap-around in both directions and the compare match each take only a handful of phase steps.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FCNT_W      = 3,
  parameter int FPER_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              index_in,
  input  logic              home_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int POS_W = 2 * DATA_W;
  localparam logic [3:0] A_CTL = 4'd0, A_CTL2 = 4'd1, A_FILT = 4'd2,
    A_INITH = 4'd3, A_INITL = 4'd4, A_MODH = 4'd5, A_MODL = 4'd6,
    A_CMPH = 4'd7, A_CMPL = 4'd8, A_POSH = 4'd9, A_HPOSH = 4'd10,
    A_HPOSL = 4'd11, A_DIFF = 4'd12, A_HDIFF = 4'd13, A_REV = 4'd14,
    A_HREV = 4'd15;

  logic rev_dir, sp_mode, idx_en, idx_fall, home_en, home_fall;
  logic idx_ie, home_ie, cmp_ie, idx_flag, home_flag, cmp_flag;
  logic mod_en, rev_mode, trig_zero, trig_hold, ro_ie, ru_ie, ro_flag, ru_flag;
  logic [FCNT_W-1:0] filt_cnt;
  logic [FPER_W-1:0] filt_per, per_cnt;
  logic [POS_W-1:0] init_r, mod_r, cmp_r, pos_q, pos_d, hold_pos;
  logic [DATA_W-1:0] diff_q, diff_d, rev_q, rev_d, hold_diff, hold_rev;
  logic [SYNC_STAGES-1:0] sa, sb, si, sh;
  logic [1:0] filt, fprev, fin;
  logic [FCNT_W:0] mcnt [2];
  logic idx_p, home_p, dir_up_q;

  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire wr_ctl2 = bus_wr && bus_addr == A_CTL2;
  wire swinit  = wr_ctl && bus_wdata[0];
  wire snap    = bus_rd && bus_addr == A_POSH;
  wire tick    = per_cnt == filt_per;
  assign fin   = {sa[SYNC_STAGES-1], sb[SYNC_STAGES-1]};

  wire idx_s   = si[SYNC_STAGES-1];
  wire home_s  = sh[SYNC_STAGES-1];
  wire idx_evt  = idx_fall  ? (~idx_s & idx_p)   : (idx_s & ~idx_p);
  wire home_evt = home_fall ? (~home_s & home_p) : (home_s & ~home_p);
  wire trig_load = (idx_evt & idx_en) | (home_evt & home_en);
  wire take_hold = snap | (trig_hold & trig_load);

  logic q_up, q_dn, raw_up, raw_dn, cnt_up, cnt_dn;
  always_comb begin
    q_up = (fprev == 2'b00 && filt == 2'b10) || (fprev == 2'b10 && filt == 2'b11) ||
           (fprev == 2'b11 && filt == 2'b01) || (fprev == 2'b01 && filt == 2'b00);
    q_dn = (fprev == 2'b10 && filt == 2'b00) || (fprev == 2'b11 && filt == 2'b10) ||
           (fprev == 2'b01 && filt == 2'b11) || (fprev == 2'b00 && filt == 2'b01);
    raw_up = sp_mode ? (filt[1] & ~fprev[1] & ~filt[0]) : q_up;
    raw_dn = sp_mode ? (filt[1] & ~fprev[1] &  filt[0]) : q_dn;
    cnt_up = rev_dir ? raw_dn : raw_up;
    cnt_dn = rev_dir ? raw_up : raw_dn;
  end

  logic ro_evt, ru_evt, c_up, c_dn;
  always_comb begin
    pos_d = pos_q; ro_evt = 1'b0; ru_evt = 1'b0; c_up = 1'b0; c_dn = 1'b0;
    if (swinit) pos_d = init_r;
    else if (trig_load) pos_d = trig_zero ? '0 : init_r;
    else if (cnt_up) begin
      c_up = 1'b1;
      if (mod_en && pos_q == mod_r) begin pos_d = init_r; ro_evt = 1'b1; end
      else begin pos_d = pos_q + 1'b1; ro_evt = !mod_en && pos_q == '1; end
    end else if (cnt_dn) begin
      c_dn = 1'b1;
      if (mod_en && pos_q == init_r) begin pos_d = mod_r; ru_evt = 1'b1; end
      else begin pos_d = pos_q - 1'b1; ru_evt = !mod_en && pos_q == '0; end
    end
    diff_d = take_hold ? '0 : diff_q;
    if (c_up) diff_d = diff_d + 1'b1;
    else if (c_dn) diff_d = diff_d - 1'b1;
    rev_d = rev_q;
    if (!rev_mode && idx_evt) rev_d = dir_up_q ? rev_q + 1'b1 : rev_q - 1'b1;
    else if (rev_mode && ro_evt) rev_d = rev_q + 1'b1;
    else if (rev_mode && ru_evt) rev_d = rev_q - 1'b1;
  end

  wire cmp_evt = (pos_d != pos_q) && (pos_d == cmp_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa <= '0; sb <= '0; si <= '0; sh <= '0;
      filt <= '0; fprev <= '0; per_cnt <= '0;
      mcnt[0] <= '0; mcnt[1] <= '0;
      idx_p <= 1'b0; home_p <= 1'b0; dir_up_q <= 1'b1;
      {rev_dir, sp_mode, idx_en, idx_fall, home_en, home_fall} <= '0;
      {idx_ie, home_ie, cmp_ie, idx_flag, home_flag, cmp_flag} <= '0;
      {mod_en, rev_mode, trig_zero, trig_hold, ro_ie, ru_ie, ro_flag, ru_flag} <= '0;
      filt_cnt <= '0; filt_per <= '0;
      init_r <= '0; mod_r <= '0; cmp_r <= '1; pos_q <= '0; hold_pos <= '0;
      diff_q <= '0; rev_q <= '0; hold_diff <= '0; hold_rev <= '0;
    end else begin
      sa <= {sa[SYNC_STAGES-2:0], phase_a};
      sb <= {sb[SYNC_STAGES-2:0], phase_b};
      si <= {si[SYNC_STAGES-2:0], index_in};
      sh <= {sh[SYNC_STAGES-2:0], home_in};
      idx_p <= idx_s; home_p <= home_s;
      per_cnt <= tick ? '0 : per_cnt + 1'b1;
      for (int k = 0; k < 2; k++) begin
        if (tick) begin
          if (fin[k] != filt[k]) begin
            if (mcnt[k] == {1'b0, filt_cnt}) begin
              filt[k] <= fin[k];
              mcnt[k] <= '0;
            end else mcnt[k] <= mcnt[k] + 1'b1;
          end else mcnt[k] <= '0;
        end
      end
      fprev <= filt;
      pos_q <= pos_d; diff_q <= diff_d; rev_q <= rev_d;
      if (c_up) dir_up_q <= 1'b1;
      else if (c_dn) dir_up_q <= 1'b0;
      if (take_hold) begin hold_pos <= pos_q; hold_diff <= diff_q; hold_rev <= rev_q; end
      idx_flag  <= idx_evt  | (idx_flag  & ~(wr_ctl  & bus_wdata[8]));
      home_flag <= home_evt | (home_flag & ~(wr_ctl  & bus_wdata[10]));
      cmp_flag  <= cmp_evt  | (cmp_flag  & ~(wr_ctl  & bus_wdata[12]));
      ro_flag   <= ro_evt   | (ro_flag   & ~(wr_ctl2 & bus_wdata[5]));
      ru_flag   <= ru_evt   | (ru_flag   & ~(wr_ctl2 & bus_wdata[7]));
      if (bus_wr) begin
        case (bus_addr)
          A_CTL: begin
            {home_fall, home_en, idx_fall, idx_en, sp_mode, rev_dir} <= bus_wdata[6:1];
            idx_ie <= bus_wdata[7]; home_ie <= bus_wdata[9]; cmp_ie <= bus_wdata[11];
          end
          A_CTL2: begin
            {ro_ie, trig_hold, trig_zero, rev_mode, mod_en} <= bus_wdata[4:0];
            ru_ie <= bus_wdata[6];
          end
          A_FILT: {filt_per, filt_cnt} <= bus_wdata[FPER_W+FCNT_W-1:0];
          A_INITH: init_r[POS_W-1:DATA_W] <= bus_wdata;
          A_INITL: init_r[DATA_W-1:0]     <= bus_wdata;
          A_MODH:  mod_r[POS_W-1:DATA_W]  <= bus_wdata;
          A_MODL:  mod_r[DATA_W-1:0]      <= bus_wdata;
          A_CMPH:  cmp_r[POS_W-1:DATA_W]  <= bus_wdata;
          A_CMPL:  cmp_r[DATA_W-1:0]      <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = DATA_W'({cmp_flag, cmp_ie, home_flag, home_ie, idx_flag, idx_ie,
                                    home_fall, home_en, idx_fall, idx_en, sp_mode, rev_dir, 1'b0});
      A_CTL2:  bus_rdata = DATA_W'({ru_flag, ru_ie, ro_flag, ro_ie, trig_hold, trig_zero,
                                    rev_mode, mod_en});
      A_FILT:  bus_rdata = DATA_W'({filt_per, filt_cnt});
      A_INITH: bus_rdata = init_r[POS_W-1:DATA_W];
      A_INITL: bus_rdata = init_r[DATA_W-1:0];
      A_MODH:  bus_rdata = mod_r[POS_W-1:DATA_W];
      A_MODL:  bus_rdata = mod_r[DATA_W-1:0];
      A_CMPH:  bus_rdata = cmp_r[POS_W-1:DATA_W];
      A_CMPL:  bus_rdata = cmp_r[DATA_W-1:0];
      A_POSH:  bus_rdata = pos_q[POS_W-1:DATA_W];
      A_HPOSH: bus_rdata = hold_pos[POS_W-1:DATA_W];
      A_HPOSL: bus_rdata = hold_pos[DATA_W-1:0];
      A_DIFF:  bus_rdata = diff_q;
      A_HDIFF: bus_rdata = hold_diff;
      A_REV:   bus_rdata = rev_q;
      default: bus_rdata = hold_rev;
    endcase
  end

  assign irq = (idx_flag & idx_ie) | (home_flag & home_ie) | (cmp_flag & cmp_ie) |
               (ro_flag & ro_ie) | (ru_flag & ru_ie);

  p_swinit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swinit |=> pos_q == $past(init_r));
  p_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt ^ fprev) == 2'b11 && !sp_mode && !swinit && !trig_load) |=> pos_q == $past(pos_q));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && cnt_up && pos_q == mod_r && !swinit && !trig_load) |=> (pos_q == $past(init_r) && ro_flag));
  p_snap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (hold_pos == $past(pos_q) && hold_rev == $past(rev_q) && hold_diff == $past(diff_q)));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_flag && !(wr_ctl && bus_wdata[8])) |=> idx_flag);
  p_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q) && pos_q == $past(cmp_r)) |-> cmp_flag);
endmodule

// File: tb/quad_pos_counter_tb.sv
module quad_pos_counter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic phase_a = 0, phase_b = 0, index_in = 0, home_in = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int total = 0, fails = 0;
  bit done = 0;
  logic qa = 0, qb = 0;

  always #2.5 clk = ~clk;

  quad_pos_counter u_dut (.clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .index_in(index_in), .home_in(home_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic read_pos(output logic [31:0] p);
    logic [15:0] hi, lo;
    rd(4'd9, hi); rd(4'd11, lo); p = {hi, lo};
  endtask

  task automatic wr32(input logic [3:0] hi_a, input logic [31:0] v);
    wr(hi_a, v[31:16]); wr(hi_a + 4'd1, v[15:0]);
  endtask

  task automatic qset(input logic a, input logic b, input int w);
    @(negedge clk); phase_a = a; phase_b = b; qa = a; qb = b;
    repeat (w) @(negedge clk);
  endtask

  task automatic step(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      logic na, nb;
      case ({qa, qb})
        2'b00: {na, nb} = up ? 2'b10 : 2'b01;
        2'b10: {na, nb} = up ? 2'b11 : 2'b00;
        2'b11: {na, nb} = up ? 2'b01 : 2'b10;
        default: {na, nb} = up ? 2'b00 : 2'b11;
      endcase
      qset(na, nb, 6);
    end
  endtask

  task automatic pulse_idx();
    @(negedge clk); index_in = 1; repeat (6) @(negedge clk);
    index_in = 0; repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic [31:0] p;
    chk("R1 irq", irq, 0);
    rd(4'd0, d); chk("R1 ctl", d, 0);
    rd(4'd7, d); chk("R1 cmp hi", d, 16'hFFFF);
    rd(4'd8, d); chk("R1 cmp lo", d, 16'hFFFF);
    read_pos(p); chk("R1 pos", p, 0);
  endtask

  task automatic t_quad();
    logic [31:0] p;
    step(1, 5); read_pos(p); chk("R2 up", p, 5);
    step(0, 2); read_pos(p); chk("R2 down", p, 3);
    wr(4'd0, 16'h0002); step(1, 2); read_pos(p); chk("R2 reverse", p, 1);
    wr(4'd0, 16'h0000);
  endtask

  task automatic t_illegal();
    logic [31:0] p;
    qset(~qa, ~qb, 8); read_pos(p); chk("R3 double toggle", p, 1);
    step(1, 1); read_pos(p); chk("R3 resume", p, 2);
  endtask

  task automatic t_swinit();
    logic [31:0] p;
    wr32(4'd3, 32'h1234_5678); wr(4'd0, 16'h0001);
    read_pos(p); chk("R5 load", p, 32'h1234_5678);
  endtask

  task automatic t_single();
    logic [31:0] p;
    wr(4'd0, 16'h0004); qset(0, 0, 8);
    wr32(4'd3, 0); wr(4'd0, 16'h0005);
    for (int i = 0; i < 3; i++) begin qset(1, 0, 6); qset(0, 0, 6); end
    read_pos(p); chk("R4 up pulses", p, 3);
    qset(0, 1, 6); read_pos(p); chk("R4 B alone", p, 3);
    for (int i = 0; i < 2; i++) begin qset(1, 1, 6); qset(0, 1, 6); end
    read_pos(p); chk("R4 down pulses", p, 1);
    qset(0, 0, 6); wr(4'd0, 16'h0000);
  endtask

  task automatic t_index();
    logic [31:0] p; logic [15:0] d;
    wr32(4'd3, 100); wr(4'd0, 16'h0001);
    wr(4'd0, 16'h0008); step(1, 3); pulse_idx();
    read_pos(p); chk("R6 index rise reload", p, 100);
    rd(4'd0, d); chk("R6 index flag", d[8], 1);
    wr(4'd0, 16'h0018); step(1, 2);
    @(negedge clk); index_in = 1; repeat (6) @(negedge clk);
    read_pos(p); chk("R6 falling ignores rise", p, 102);
    @(negedge clk); index_in = 0; repeat (6) @(negedge clk);
    read_pos(p); chk("R6 falling reload", p, 100);
    wr(4'd0, 16'h0020); step(1, 1);
    @(negedge clk); home_in = 1; repeat (6) @(negedge clk);
    read_pos(p); chk("R6 home reload", p, 100);
    rd(4'd0, d); chk("R6 home flag", d[10], 1);
    @(negedge clk); home_in = 0; repeat (6) @(negedge clk);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(4'd0, 16'h0100); rd(4'd0, d);
    chk("R10 index cleared", d[8], 0); chk("R10 home kept", d[10], 1);
    wr(4'd0, 16'h0400); rd(4'd0, d); chk("R10 home cleared", d[10], 0);
  endtask

  task automatic t_modulo();
    logic [31:0] p; logic [15:0] d, r0;
    wr32(4'd3, 2); wr32(4'd5, 4); wr(4'd1, 16'h0003); wr(4'd0, 16'h0001);
    rd(4'd14, r0);
    step(1, 2); read_pos(p); chk("R7 at modulus", p, 4);
    step(1, 1); read_pos(p); chk("R7 roll-over value", p, 2);
    rd(4'd1, d); chk("R7 roll-over flag", d[5], 1);
    rd(4'd14, d); chk("R8 rev on roll-over", d, r0 + 16'd1);
    step(0, 1); read_pos(p); chk("R7 roll-under value", p, 4);
    rd(4'd1, d); chk("R7 roll-under flag", d[7], 1);
    rd(4'd14, d); chk("R8 rev on roll-under", d, r0);
    wr(4'd1, 16'h00A3); rd(4'd1, d); chk("R10 ctl2 flags cleared", d, 16'h0003);
    wr(4'd1, 16'h0000);
  endtask

  task automatic t_rev_idx();
    logic [15:0] d, r0;
    wr(4'd0, 16'h0000);
    step(1, 1); rd(4'd14, r0); pulse_idx();
    rd(4'd14, d); chk("R8 index up", d, r0 + 16'd1);
    step(0, 1); pulse_idx();
    rd(4'd14, d); chk("R8 index down", d, r0);
    wr(4'd0, 16'h0100);
  endtask

  task automatic t_cmp();
    logic [15:0] d;
    wr32(4'd3, 0); wr(4'd0, 16'h1001); wr32(4'd7, 3);
    step(1, 2); rd(4'd0, d); chk("R9 no match yet", d[12], 0);
    step(1, 1); rd(4'd0, d); chk("R9 match flag", d[12], 1);
    chk("R13 irq masked", irq, 0);
    wr(4'd0, 16'h0800); chk("R13 irq enabled", irq, 1);
    wr(4'd0, 16'h1800); chk("R13 irq after clear", irq, 0);
    wr(4'd0, 16'h0000); wr32(4'd7, 32'hFFFF_FFFF);
  endtask

  task automatic t_snapshot();
    logic [31:0] p; logic [15:0] d, hi;
    wr32(4'd3, 32'h0001_FFFE); wr(4'd0, 16'h0001);
    rd(4'd9, d); step(1, 3);
    rd(4'd12, d); chk("R11 diff live", d, 3);
    rd(4'd9, hi); step(1, 1);
    rd(4'd11, d); chk("R11 coherent halves", {hi, d}, 32'h0002_0001);
    rd(4'd13, d); chk("R11 held diff", d, 3);
    rd(4'd12, d); chk("R11 diff restarted", d, 1);
    read_pos(p); chk("R11 live pos", p, 32'h0002_0002);
  endtask

  task automatic t_trig_opt();
    logic [31:0] p; logic [15:0] d;
    wr32(4'd3, 50); wr(4'd0, 16'h0001); wr(4'd1, 16'h000C);
    step(1, 4); wr(4'd0, 16'h0008); pulse_idx();
    rd(4'd11, d); chk("R14 hold on trigger", d, 54);
    read_pos(p); chk("R14 trigger zero", p, 0);
    wr(4'd1, 16'h0000); wr(4'd0, 16'h0100);
  endtask

  task automatic t_filter();
    logic [31:0] p0, p;
    logic na, nb, oa, ob;
    read_pos(p0);
    wr(4'd2, 16'h000B);
    oa = qa; ob = qb;
    case ({qa, qb})
      2'b00: {na, nb} = 2'b10; 2'b10: {na, nb} = 2'b11;
      2'b11: {na, nb} = 2'b01; default: {na, nb} = 2'b00;
    endcase
    qset(na, nb, 3); qset(oa, ob, 20);
    read_pos(p); chk("R12 glitch rejected", p, p0);
    qset(na, nb, 24);
    read_pos(p); chk("R12 steady accepted", p, p0 + 1);
    wr(4'd2, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset(); t_quad(); t_illegal(); t_swinit(); t_single(); t_index(); t_w1c();
    t_modulo(); t_rev_idx(); t_cmp(); t_snapshot(); t_trig_opt(); t_filter();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule